// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Stall Control

This block sits in the decode stage of a five-stage, fully bypassed pipeline. It chooses where each of the two decode operands comes from: the register file, the execute result, the memory-stage result or the writeback value. It works this out by comparing the decode source fields against the destination of every older instruction that is still in flight. It does not hold the forwarding multiplexers or the register file. It only drives their select lines.

With every forwarding path present, one hazard is left over. A load in execute has no data until the end of its memory access. When the decode instruction reads that load's destination, this block raises a stall for one cycle. After that cycle the load sits in the memory stage and is forwarded from there. Link-writing jumps return the link PC as their execute result, so they forward like ordinary ALU results and never stall.

The whole block is combinational. Decode drives it with the source fields and their read enables. Each of the three older stages supplies its opcode, its destination register and its valid bit.

Top module: `bypass_unit`

## Requirements
- R1: Opcode codes are ALU=0, ALUI=1, LW=2, SW=3, BZ=4, J=5, JAL=6, JR=7, JALR=8, NOP=15. Only ALU, ALUI, LW, JAL and JALR write a register. A stage holding any other opcode never causes forwarding or a stall.
- R2: The operand select encoding is 2 bits: 0 = register file, 1 = execute result, 2 = memory-stage result, 3 = writeback value. With no matching older writer, the select is 0.
- R3: When more than one stage writes the operand's register, the youngest one wins: execute over memory, and memory over writeback.
- R4: A source field of register 0 always selects 0 and never causes a stall. A writer whose destination is register 0 is never forwarded.
- R5: An operand whose read enable is low selects 0 and does not contribute to the stall.
- R6: A stage whose valid bit is low is ignored for both forwarding and stalling.
- R7: The stall is high exactly when the execute stage holds a valid LW with a nonzero destination, and that destination equals a read source (rs with its read enable, or rt with its read enable).
- R8: An LW in the memory stage forwards with select 2, and an LW in the writeback stage forwards with select 3. Neither one stalls.
- R9: A JAL or JALR in execute forwards its link value with select 1 and does not stall.
- R10: When a load in execute matches an operand, that operand's select is 1 while the stall is high. An older matching stage does not take its place.
- R11: The A and B selects are resolved independently of each other and may pick different stages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decRs | input | 5 | Decode first source register |
| decRsRd | input | 1 | Decode reads the first source |
| decRt | input | 5 | Decode second source register |
| decRtRd | input | 1 | Decode reads the second source |
| exeOp | input | 4 | Execute-stage opcode |
| exeDst | input | 5 | Execute-stage destination register |
| exeVld | input | 1 | Execute stage holds a live instruction |
| memOp | input | 4 | Memory-stage opcode |
| memDst | input | 5 | Memory-stage destination register |
| memVld | input | 1 | Memory stage holds a live instruction |
| wbOp | input | 4 | Writeback-stage opcode |
| wbDst | input | 5 | Writeback-stage destination register |
| wbVld | input | 1 | Writeback stage holds a live instruction |
| selA | output | 2 | First operand source select |
| selB | output | 2 | Second operand source select |
| stall | output | 1 | Hold decode and fetch for one cycle |

## Verification
The assertions take for granted that each stage's destination field is meaningful only while that stage is valid, and that opcodes come from the listed codes. Because of this, a select that points at a stage is checked only against that stage's valid bit and destination. The vector table keeps to the listed opcodes and drives the NOP code into idle stages. It sets invalid stages to destinations that would match, so that the valid qualification is really tested. The directed sweep drives a load in execute against every source register, including register 0.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int REG_W  = 5;
  localparam int OP_W   = 4;
  localparam int N_PROD = 3;               // execute, memory, writeback
  localparam int SEL_W  = $clog2(N_PROD + 1);

  typedef enum logic [OP_W-1:0] {
    OP_ALU  = 4'd0,
    OP_ALUI = 4'd1,
    OP_LW   = 4'd2,
    OP_SW   = 4'd3,
    OP_BZ   = 4'd4,
    OP_J    = 4'd5,
    OP_JAL  = 4'd6,
    OP_JR   = 4'd7,
    OP_JALR = 4'd8,
    OP_NOP  = 4'd15
  } opcode_e;

  // Strobes from the compare datapath to the select control.
  typedef struct packed {
    logic [N_PROD-1:0] hitA;    // bit 0 = execute, 1 = memory, 2 = writeback
    logic [N_PROD-1:0] hitB;
    logic              exeLoad; // execute holds a live load with nonzero destination
  } hazStrobe_t;

  function automatic logic writesReg(input logic [OP_W-1:0] op);
    case (op)
      OP_ALU, OP_ALUI, OP_LW, OP_JAL, OP_JALR: writesReg = 1'b1;
      default:                                  writesReg = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hazard_match.sv
module hazard_match
  import bypass_pkg::*;
#(
  parameter int RegW  = REG_W,
  parameter int NProd = N_PROD
) (
  input  logic [RegW-1:0] decRs,
  input  logic            decRsRd,
  input  logic [RegW-1:0] decRt,
  input  logic            decRtRd,
  input  logic [OP_W-1:0] prodOp  [NProd],
  input  logic [RegW-1:0] prodDst [NProd],
  input  logic            prodVld [NProd],
  output hazStrobe_t      strobes
);
  logic [NProd-1:0] writer;

  for (genvar g = 0; g < NProd; g++) begin : g_stage
    // A nonzero destination keeps register 0 out of every match.
    assign writer[g] = prodVld[g] && writesReg(prodOp[g]) && (prodDst[g] != '0);
    assign strobes.hitA[g] = writer[g] && decRsRd && (prodDst[g] == decRs);
    assign strobes.hitB[g] = writer[g] && decRtRd && (prodDst[g] == decRt);
  end

  assign strobes.exeLoad = writer[0] && (prodOp[0] == OP_LW);
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int NProd = N_PROD,
  parameter int SelW  = SEL_W
) (
  input  hazStrobe_t      strobes,
  output logic [SelW-1:0] selA,
  output logic [SelW-1:0] selB,
  output logic            stall
);
  // Walk from oldest to youngest so the youngest hit overwrites.
  always_comb begin
    selA = '0;
    selB = '0;
    for (int g = NProd - 1; g >= 0; g--) begin
      if (strobes.hitA[g]) selA = SelW'(g + 1);
      if (strobes.hitB[g]) selB = SelW'(g + 1);
    end
  end

  assign stall = strobes.exeLoad && (strobes.hitA[0] || strobes.hitB[0]);
endmodule

// File: rtl/bypass_unit.sv
module bypass_unit
  import bypass_pkg::*;
(
  input  logic [4:0] decRs,
  input  logic       decRsRd,
  input  logic [4:0] decRt,
  input  logic       decRtRd,
  input  logic [3:0] exeOp,
  input  logic [4:0] exeDst,
  input  logic       exeVld,
  input  logic [3:0] memOp,
  input  logic [4:0] memDst,
  input  logic       memVld,
  input  logic [3:0] wbOp,
  input  logic [4:0] wbDst,
  input  logic       wbVld,
  output logic [1:0] selA,
  output logic [1:0] selB,
  output logic       stall
);
  logic [OP_W-1:0]  prodOp  [N_PROD];
  logic [REG_W-1:0] prodDst [N_PROD];
  logic             prodVld [N_PROD];
  hazStrobe_t       strobes;

  assign prodOp  = '{exeOp, memOp, wbOp};
  assign prodDst = '{exeDst, memDst, wbDst};
  assign prodVld = '{exeVld, memVld, wbVld};

  hazard_match #(.RegW(REG_W), .NProd(N_PROD)) uMatch (
    .decRs(decRs), .decRsRd(decRsRd), .decRt(decRt), .decRtRd(decRtRd),
    .prodOp(prodOp), .prodDst(prodDst), .prodVld(prodVld),
    .strobes(strobes)
  );

  bypass_ctrl #(.NProd(N_PROD), .SelW(SEL_W)) uCtrl (
    .strobes(strobes), .selA(selA), .selB(selB), .stall(stall)
  );
endmodule

// File: rtl/bypass_unit_chk.sv
module bypass_unit_chk (
  input logic [4:0] decRs,
  input logic       decRsRd,
  input logic [4:0] decRt,
  input logic       decRtRd,
  input logic [3:0] exeOp,
  input logic [4:0] exeDst,
  input logic       exeVld,
  input logic [4:0] memDst,
  input logic       memVld,
  input logic [4:0] wbDst,
  input logic       wbVld,
  input logic [1:0] selA,
  input logic [1:0] selB,
  input logic       stall
);
  always_comb begin
    if (stall) begin
      p_stall_src_r7: assert (exeVld && exeOp == 4'd2 && exeDst != 5'd0)
        else $error("stall without a live load in execute");
      p_stall_sel_r10: assert (selA == 2'd1 || selB == 2'd1)
        else $error("stall while no operand points at execute");
    end
    if (decRs == 5'd0) begin
      p_zero_rs_r4: assert (selA == 2'd0) else $error("register 0 forwarded on A");
    end
    if (decRt == 5'd0) begin
      p_zero_rt_r4: assert (selB == 2'd0) else $error("register 0 forwarded on B");
    end
    if (!decRsRd) begin
      p_unread_a_r5: assert (selA == 2'd0) else $error("unread A operand forwarded");
    end
    if (!decRtRd) begin
      p_unread_b_r5: assert (selB == 2'd0) else $error("unread B operand forwarded");
    end
    if (!decRsRd && !decRtRd) begin
      p_no_read_no_stall_r5: assert (!stall) else $error("stall with no operand read");
    end
    if (selA == 2'd1) begin
      p_exe_pick_r6: assert (exeVld && exeDst == decRs) else $error("A picks dead execute");
    end
    if (selA == 2'd2) begin
      p_mem_pick_r6: assert (memVld && memDst == decRs) else $error("A picks dead memory");
    end
    if (selB == 2'd3) begin
      p_wb_pick_r6: assert (wbVld && wbDst == decRt) else $error("B picks dead writeback");
    end
  end
endmodule

bind bypass_unit bypass_unit_chk uChk (
  .decRs(decRs), .decRsRd(decRsRd), .decRt(decRt), .decRtRd(decRtRd),
  .exeOp(exeOp), .exeDst(exeDst), .exeVld(exeVld),
  .memDst(memDst), .memVld(memVld), .wbDst(wbDst), .wbVld(wbVld),
  .selA(selA), .selB(selB), .stall(stall)
);

// File: tb/bypass_unit_test.sv
module bypass_unit_test;
  import bypass_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [4:0] decRs, decRt, exeDst, memDst, wbDst;
  logic       decRsRd, decRtRd, exeVld, memVld, wbVld;
  logic [3:0] exeOp, memOp, wbOp;
  logic [1:0] selA, selB;
  logic       stall;

  bypass_unit uut (.*);

  typedef struct packed {
    logic [4:0] rs; logic rsRd; logic [4:0] rt; logic rtRd;
    logic [3:0] eOp; logic [4:0] eDst; logic eV;
    logic [3:0] mOp; logic [4:0] mDst; logic mV;
    logic [3:0] wOp; logic [4:0] wDst; logic wV;
    logic [1:0] expA; logic [1:0] expB; logic expSt;
  } vec_t;

  localparam int NVEC = 15;
  //                    rs    rd  rt    rd  eOp      eDst  eV  mOp      mDst  mV  wOp      wDst  wV  A  B  st
  localparam vec_t VEC [NVEC] = '{
    '{5'd1, 1, 5'd2, 1, OP_NOP,  5'd1, 0, OP_NOP,  5'd2, 0, OP_NOP,  5'd1, 0, 0, 0, 0}, // R2 R6 idle
    '{5'd1, 1, 5'd2, 1, OP_ALU,  5'd1, 1, OP_NOP,  5'd0, 0, OP_NOP,  5'd0, 0, 1, 0, 0}, // R2 execute
    '{5'd1, 1, 5'd2, 1, OP_NOP,  5'd0, 0, OP_ALUI, 5'd2, 1, OP_NOP,  5'd0, 0, 0, 2, 0}, // R2 memory
    '{5'd1, 1, 5'd2, 1, OP_ALU,  5'd1, 1, OP_ALU,  5'd1, 1, OP_ALU,  5'd1, 1, 1, 0, 0}, // R3 exe wins
    '{5'd1, 1, 5'd2, 1, OP_NOP,  5'd0, 0, OP_ALU,  5'd1, 1, OP_ALUI, 5'd1, 1, 2, 0, 0}, // R3 mem over wb
    '{5'd1, 1, 5'd2, 1, OP_NOP,  5'd0, 0, OP_NOP,  5'd0, 0, OP_ALU,  5'd2, 1, 0, 3, 0}, // R2 writeback
    '{5'd1, 1, 5'd2, 1, OP_LW,   5'd1, 1, OP_NOP,  5'd0, 0, OP_NOP,  5'd0, 0, 1, 0, 1}, // R7 load-use on rs
    '{5'd1, 1, 5'd2, 1, OP_LW,   5'd2, 1, OP_ALU,  5'd2, 1, OP_NOP,  5'd0, 0, 0, 1, 1}, // R10 load shadows mem
    '{5'd1, 0, 5'd2, 0, OP_LW,   5'd1, 1, OP_ALU,  5'd2, 1, OP_NOP,  5'd0, 0, 0, 0, 0}, // R5 read enables low
    '{5'd1, 1, 5'd2, 1, OP_NOP,  5'd0, 0, OP_LW,   5'd1, 1, OP_LW,   5'd2, 1, 2, 3, 0}, // R8 older loads
    '{5'd31,1, 5'd5, 1, OP_JAL,  5'd31,1, OP_NOP,  5'd0, 0, OP_NOP,  5'd0, 0, 1, 0, 0}, // R9 JAL link
    '{5'd1, 1, 5'd7, 1, OP_JALR, 5'd7, 1, OP_NOP,  5'd0, 0, OP_ALU,  5'd7, 1, 0, 1, 0}, // R9 JALR link
    '{5'd1, 1, 5'd1, 1, OP_SW,   5'd1, 1, OP_BZ,   5'd1, 1, OP_J,    5'd1, 1, 0, 0, 0}, // R1 non-writers
    '{5'd3, 1, 5'd4, 1, OP_ALUI, 5'd3, 1, OP_JR,   5'd4, 1, OP_LW,   5'd4, 1, 1, 3, 0}, // R11 R1 split
    '{5'd1, 1, 5'd0, 1, OP_ALU,  5'd1, 0, OP_NOP,  5'd0, 0, OP_ALU,  5'd1, 1, 3, 0, 0}  // R6 dead exe
  };

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [1:0] gotA, input logic [1:0] expA,
                       input logic [1:0] gotB, input logic [1:0] expB,
                       input logic gotS, input logic expS);
    checks++;
    if (gotA !== expA || gotB !== expB || gotS !== expS) begin
      fails++;
      $display("FAIL %s: selA=%0d selB=%0d stall=%0d expected selA=%0d selB=%0d stall=%0d",
               req, gotA, gotB, gotS, expA, expB, expS);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    decRs = v.rs; decRsRd = v.rsRd; decRt = v.rt; decRtRd = v.rtRd;
    exeOp = v.eOp; exeDst = v.eDst; exeVld = v.eV;
    memOp = v.mOp; memDst = v.mDst; memVld = v.mV;
    wbOp  = v.wOp; wbDst  = v.wDst; wbVld  = v.wV;
    #5;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    decRs = '0; decRsRd = 0; decRt = '0; decRtRd = 0;
    exeOp = OP_NOP; exeDst = '0; exeVld = 0;
    memOp = OP_NOP; memDst = '0; memVld = 0;
    wbOp = OP_NOP; wbDst = '0; wbVld = 0;
    #5;
    // Quiescent state with every stage empty: R2 R6
    check("R2 quiescent", selA, 2'd0, selB, 2'd0, stall, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      check($sformatf("vector %0d", i), selA, VEC[i].expA, selB, VEC[i].expB, stall, VEC[i].expSt);
    end

    // R4 R7: load in execute against every rs; only nonzero registers stall
    for (int r = 0; r < 32; r++) begin
      v = '{5'(r), 1, 5'd0, 0, OP_LW, 5'(r), 1, OP_ALU, 5'(r), 1, OP_NOP, 5'd0, 0,
            (r != 0) ? 2'd1 : 2'd0, 2'd0, (r != 0)};
      drive(v);
      check($sformatf("R4/R7 sweep rs=%0d", r), selA, v.expA, selB, v.expB, stall, v.expSt);
    end

    // R4: destination 0 never forwarded even when source is 0 and stages write
    v = '{5'd0, 1, 5'd0, 1, OP_ALU, 5'd0, 1, OP_LW, 5'd0, 1, OP_JAL, 5'd0, 1, 2'd0, 2'd0, 1'b0};
    drive(v);
    check("R4 register zero", selA, 2'd0, selB, 2'd0, stall, 1'b0);

    // R7 via rt only, rs unrelated
    v = '{5'd9, 1, 5'd12, 1, OP_LW, 5'd12, 1, OP_NOP, 5'd0, 0, OP_ALU, 5'd9, 1, 2'd3, 2'd1, 1'b1};
    drive(v);
    check("R7 load-use on rt", selA, 2'd3, selB, 2'd1, stall, 1'b1);

    // R6: invalid load in execute does not stall
    v = '{5'd12, 1, 5'd12, 1, OP_LW, 5'd12, 0, OP_NOP, 5'd0, 0, OP_NOP, 5'd0, 0, 2'd0, 2'd0, 1'b0};
    drive(v);
    check("R6 dead load", selA, 2'd0, selB, 2'd0, stall, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule